// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day count for a precision time protocol hardware clock. On each cycle of its clock, it adds a 40-bit fixed-point increment to the count. The increment has 8 integer and 32 fractional nanosecond bits. The fraction builds up in a 32-bit accumulator that sits below the visible time. The 64-bit range is large enough that wrap-around is never handled.

Software reaches the block through a simple 32-bit register strobe interface. Read data appears one cycle after the read strobe.

- **Reading time:** a read of the low time word captures the whole 64-bit value. A later read of the high word returns the captured upper half.
- **Writing time and increment:** writes are split in two. The low word is staged first. The new value takes effect only when the high word is written.
- **Link speed:** the link-speed input picks a default increment. At 100 Mbit/s, counting stops.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time is 0, the control enable reads 0, the increment is 0x01_9999_9999 and reg_rdata is 0.
- R2: While running, each cycle adds the increment to {time, fraction}. After n ticks from a load, the time equals the loaded value plus floor(n*inc/2^32).
- R3: Bit 0 of the control register (address 0) is the count enable and reads back there. While it is 0, the time holds.
- R4: A read of address 1 returns the live time bits 31:0 and latches all 64 bits. A read of address 2 returns bits 63:32 of that latch, not the live upper half.
- R5: A write to address 1 only stages a low word. A write to address 2 loads the time with {wdata, staged low} and clears the fraction.
- R6: If a time load and a tick fall in the same cycle, the loaded value wins and the fraction is cleared.
- R7: A write to address 3 stages the low 32 increment bits. A write to address 4 applies {wdata[7:0], staged} as the increment. Before that second write, the rate is unchanged.
- R8: The link-speed codes are 0 no link, 1 100M, 2 1G, 3 10G, 4 40G (5 to 7 act as no link). A change of code loads the default increment: 0x20_0000_0000 for 1G, 0x03_3333_3333 for 10G, and 0x01_9999_9999 for all others.
- R9: While link_speed is 1 (100M), the time does not advance, even with the enable set.
- R10: If software has applied an increment since the last link-speed change, the next change keeps that increment. The change after that loads the default again. A software write in the same cycle as a change wins.
- R11: Address 3 reads back the active increment bits 31:0. Address 4 reads back bits 39:32, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_speed | input | 3 | Link-speed code (R8) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| time_ns | output | 64 | Live time of day in nanoseconds |

## Verification
The bench loads the time during an active tick, then reads it back at once. A design that let the tick win would return the load value plus one increment, and one that kept a stale fraction would drift later.

It sets the low time word just below a 32-bit boundary and lets the count carry past it between the two reads. A design without a real latch would return the incremented upper half.

It applies a software increment and then changes the link speed twice. A design that ignored the override flag, or never cleared it, would show the wrong increment after one of the two changes.

Random loads, increments and tick counts check the fixed-point sum against a 96-bit reference product.

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int TIME_W    = 64,
  parameter int FRAC_W    = 32,
  parameter int INC_INT_W = 8,
  parameter int DATA_W    = 32,
  parameter logic [INC_INT_W+FRAC_W-1:0] INC_FAST = 40'h01_9999_9999,
  parameter logic [INC_INT_W+FRAC_W-1:0] INC_MID  = 40'h03_3333_3333,
  parameter logic [INC_INT_W+FRAC_W-1:0] INC_SLOW = 40'h20_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        link_speed,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TIME_W-1:0] time_ns
);
  localparam int INC_W = INC_INT_W + FRAC_W;
  localparam int ACC_W = TIME_W + FRAC_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_TLO = 3'd1, A_THI = 3'd2, A_ILO = 3'd3, A_IHI = 3'd4;
  localparam logic [2:0] SPD_100M = 3'd1, SPD_1G = 3'd2, SPD_10G = 3'd3;

  logic              en_q, sw_inc_q;
  logic [TIME_W-1:0] time_q, latch_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INC_W-1:0]  inc_q;
  logic [DATA_W-1:0] tstage_q, istage_q, rdata_q;
  logic [2:0]        spd_q;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_tlo  = reg_wr && reg_addr == A_TLO;
  wire wr_thi  = reg_wr && reg_addr == A_THI;
  wire wr_ilo  = reg_wr && reg_addr == A_ILO;
  wire wr_ihi  = reg_wr && reg_addr == A_IHI;
  wire run     = en_q && link_speed != SPD_100M;
  wire spd_chg = link_speed != spd_q;
  wire [ACC_W-1:0] acc_next = {time_q, frac_q} + {{(ACC_W-INC_W){1'b0}}, inc_q};

  function automatic logic [INC_W-1:0] def_inc(input logic [2:0] s);
    case (s)
      SPD_1G:  def_inc = INC_SLOW;
      SPD_10G: def_inc = INC_MID;
      default: def_inc = INC_FAST;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      frac_q <= '0;
    end else if (wr_thi) begin
      time_q <= {reg_wdata, tstage_q};
      frac_q <= '0;
    end else if (run) begin
      {time_q, frac_q} <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q    <= INC_FAST;
      sw_inc_q <= 1'b0;
      spd_q    <= 3'd0;
    end else begin
      spd_q <= link_speed;
      if (wr_ihi) begin
        inc_q    <= {reg_wdata[INC_INT_W-1:0], istage_q};
        sw_inc_q <= 1'b1;
      end else if (spd_chg) begin
        if (!sw_inc_q) inc_q <= def_inc(link_speed);
        sw_inc_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tstage_q <= '0;
      istage_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (wr_tlo) tstage_q <= reg_wdata;
      if (wr_ilo) istage_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      latch_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  rdata_q <= {{(DATA_W-1){1'b0}}, en_q};
        A_TLO: begin
          rdata_q <= time_q[DATA_W-1:0];
          latch_q <= time_q;
        end
        A_THI:   rdata_q <= latch_q[TIME_W-1:DATA_W];
        A_ILO:   rdata_q <= inc_q[FRAC_W-1:0];
        A_IHI:   rdata_q <= {{(DATA_W-INC_INT_W){1'b0}}, inc_q[INC_W-1:FRAC_W]};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign time_ns   = time_q;

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_thi) |=> $stable(time_ns));
  p_stop_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_speed == SPD_100M && !wr_thi) |=> $stable(time_ns));
  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thi |=> (time_ns[TIME_W-1:DATA_W] == $past(reg_wdata) && frac_q == '0));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_thi) |=> time_ns >= $past(time_ns));
  p_inc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ihi && !spd_chg) |=> $stable(inc_q));
  p_latch_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TLO) |=> reg_rdata == $past(time_ns[DATA_W-1:0]));
endmodule

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0] link_speed = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] time_ns;
  int checks = 0, errors = 0;
  bit done = 0;

  ptp_tod_counter uut (.clk(clk), .rst_n(rst_n), .link_speed(link_speed), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_ns(time_ns));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] exp_time(logic [63:0] t0, logic [39:0] inc, int n);
    logic [95:0] acc = {t0, 32'b0} + 96'(n) * 96'(inc);
    return acc[95:32];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi);
    t = {hi, lo};
  endtask

  task automatic rd_inc(output logic [39:0] v);
    logic [31:0] lo, hi;
    rd(3'd3, lo); rd(3'd4, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic load(logic [63:0] t);
    wr(3'd1, t[31:0]); wr(3'd2, t[63:32]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, t0;
    logic [39:0] v, inc;
    int n;
    d = $urandom(32'd1234);
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 rdata", 64'(reg_rdata), 0);
    chk("R1 time_ns", time_ns, 0);
    rd(3'd0, d); chk("R1 ctrl", 64'(d), 0);
    rd_inc(v); chk("R1 inc", 64'(v), 64'h01_9999_9999);
    rd_time(t); chk("R1 time", t, 0);
    // R8 defaults per link speed
    link_speed = 3; idle(2); rd_inc(v); chk("R8 10G", 64'(v), 64'h03_3333_3333);
    link_speed = 2; idle(2); rd_inc(v); chk("R8 1G", 64'(v), 64'h20_0000_0000);
    link_speed = 4; idle(2); rd_inc(v); chk("R8 40G", 64'(v), 64'h01_9999_9999);
    // R6 load during a tick wins, fraction cleared
    wr(3'd0, 1);
    rd(3'd0, d); chk("R3 ctrl readback", 64'(d), 1);
    t0 = 64'h0000_1111_2222_3333;
    load(t0);
    rd_time(t); chk("R6 load wins", t, t0);
    wr(3'd0, 0);
    rd_time(t); chk("R6 frac cleared", t, t0 + 64'd4);
    // R3 hold while disabled
    idle(7); rd_time(t); chk("R3 hold", t, t0 + 64'd4);
    // R9 100M stops
    link_speed = 1; idle(2);
    load(64'hABCD);
    wr(3'd0, 1); idle(10);
    rd_time(t); chk("R9 stopped", t, 64'hABCD);
    wr(3'd0, 0);
    // R4 latch across a carry
    link_speed = 2; idle(2);
    load(64'h5_FFFF_FFC0);
    wr(3'd0, 1);
    rd(3'd1, d); chk("R4 low read", 64'(d), 64'hFFFF_FFC0);
    idle(5);
    rd(3'd2, d); chk("R4 latched high", 64'(d), 5);
    wr(3'd0, 0);
    rd_time(t); chk("R2 1G ticks", t, 64'h6_0000_00C0);
    // R5 low time write alone has no effect
    wr(3'd1, 32'h1234);
    rd_time(t); chk("R5 staged only", t, 64'h6_0000_00C0);
    wr(3'd2, 32'h7);
    rd_time(t); chk("R5 commit", t, 64'h7_0000_1234);
    // R7 increment staging
    wr(3'd3, 0);
    rd_inc(v); chk("R7 staged only", 64'(v), 64'h20_0000_0000);
    wr(3'd4, 5);
    rd_inc(v); chk("R7 commit R11", 64'(v), 64'h05_0000_0000);
    // R10 software increment survives one speed change
    link_speed = 3; idle(2); rd_inc(v); chk("R10 kept", 64'(v), 64'h05_0000_0000);
    link_speed = 4; idle(2); rd_inc(v); chk("R10 reloaded", 64'(v), 64'h01_9999_9999);
    // R2 random loads, increments and tick counts
    for (int i = 0; i < 12; i++) begin
      t0  = {$urandom, $urandom} >> ($urandom % 8);
      inc = {8'($urandom), 32'($urandom)} | 40'h1;
      n   = 1 + int'($urandom % 40);
      wr(3'd3, inc[31:0]); wr(3'd4, {24'b0, inc[39:32]});
      load(t0);
      wr(3'd0, 1);
      idle(n - 1);
      wr(3'd0, 0);
      rd_time(t); chk("R2 random", t, exp_time(t0, inc, n));
      rd_inc(v); chk("R11 random inc", 64'(v), 64'(inc));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule